// File: doc/BRIEF.md
# Programmable Serial Clock Generator

This block turns the system clock into the serial clock for a serial-memory sequencer. In divided mode a counter walks from zero up to a programmed wrap value N, so one serial period lasts N+1 system cycles. A second programmed count, H, marks where the high phase ends: the active phase covers counts 0 to H and the other phase covers counts H+1 to N. The usual setting is H = floor((N+1)/2 - 1), which gives a duty cycle as close to half as the divide allows. A bypass input, or a wrap value of zero, switches the block to divide-by-one, where the line runs at the rate of the system clock.

An idle-level input chooses the level the line rests at. A period always starts by leaving that level. A two-bit gating mode ties the clock to the chip-select input:
- mode 0 stops the clock as soon as chip select drops;
- mode 1 finishes the period in progress and then runs one more;
- mode 2 finishes the period in progress and then runs two more;
- mode 3 never stops the clock.

Two strobes, each one system cycle wide, mark every rising and every falling edge of the line. A sequencer uses them to shift data out and to sample data in.

Top module: `spi_clk_gen`

## Requirements
- R1: With `div_val` = N ≥ 1, no bypass and the clock running, the line repeats with a period of exactly N+1 system cycles.
- R2: With idle level low and H < N, the line is high for H+1 cycles and low for N−H cycles of each period. The high phase starts the period.
- R3: If `high_val` ≥ N, the block uses N−1 in its place, so both phases are always present.
- R4: When `bypass` is 1 or `div_val` is 0, and the clock is running, the line follows the system clock:
  - with idle level low it is low while the clock is high and high while the clock is low;
  - with idle level high it is the clock itself;
  - both strobes are 1 in every running cycle.
- R5: With `idle_high` = 1 the line rests high, and each period starts with a low phase of H+1 cycles.
- R6: In gating mode 0, the line returns to its idle level on the first edge at which `cs_active` is seen low, and no further period starts.
- R7: In gating modes 1 and 2, after `cs_active` drops, the period in progress completes and then exactly 1 (mode 1) or 2 (mode 2) further full periods follow before the line goes idle.
- R8: In gating mode 3 the clock runs whether or not `cs_active` is set.
- R9: A change of `div_val` restarts the counter at zero on the next edge, so a new full period begins with the new setting.
- R10: In divided mode:
  - `rise_stb` is 1 in exactly the cycles in which the line has just gone from low to high;
  - `fall_stb` is 1 in exactly the cycles in which the line has just gone from high to low;
  - the two strobes are never 1 together.
- R11: While `rst_n` is low, `sck`, `rise_stb` and `fall_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_val | input | DIV_W | Wrap value N; the period is N+1 cycles, and 0 selects divide-by-one |
| high_val | input | DIV_W | Last count of the active phase (H) |
| bypass | input | 1 | Forces divide-by-one |
| idle_high | input | 1 | Idle line level: 1 high, 0 low |
| gate_mode | input | 2 | 0 off with chip select, 1/2 extra periods, 3 free-running |
| cs_active | input | 1 | Chip select asserted |
| sck | output | 1 | Serial clock line |
| rise_stb | output | 1 | One-cycle strobe on each rising edge of the line |
| fall_stb | output | 1 | One-cycle strobe on each falling edge of the line |

## Verification
The bench checks the phase split against the programmed high count and against the clamp, so a design that lets H reach N would produce a line stuck high with no falling strobe. It drops chip select partway through a period in each gating mode and counts the rising strobes that follow. An off-by-one in the tail count would show up as one period too many or one too few. It also changes the divide value in the middle of a high phase. A design that does not restart its counter would produce a short, truncated high phase rather than a full new one. Finally, it samples both halves of the system clock in divide-by-one mode with each idle level, to catch an inverted or frozen line.

// File: rtl/spi_clk_pkg.sv
package spi_clk_pkg;
    // Gating behaviour relative to chip select
    typedef enum logic [1:0] {
        GATE_OFF   = 2'd0,
        GATE_TAIL1 = 2'd1,
        GATE_TAIL2 = 2'd2,
        GATE_FREE  = 2'd3
    } gate_mode_e;

    // Tail counter must hold mode + 1 for the two tail modes
    localparam int TAIL_W = 2;

    typedef struct packed {
        logic [TAIL_W-1:0] tail;
        logic              run;
    } gate_state_t;
endpackage

// File: rtl/spi_clk_gate.sv
module spi_clk_gate
    import spi_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] gate_mode,
    input  logic       cs_active,
    input  logic       period_end,
    output logic       run_nxt,
    output logic       run_cur
);
    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_active) begin
            // Arm the tail with the period in progress plus the extra ones
            if (gate_mode == GATE_TAIL1 || gate_mode == GATE_TAIL2)
                st_d.tail = TAIL_W'(gate_mode) + 1'b1;
            else
                st_d.tail = '0;
        end else if (st_q.run && period_end && st_q.tail != '0) begin
            st_d.tail = st_q.tail - 1'b1;
        end
        st_d.run = (gate_mode == GATE_FREE) || cs_active || (st_d.tail != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_nxt = st_d.run;
    assign run_cur = st_q.run;
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic [DIV_W-1:0] high_val,
    input  logic             bypass,
    input  logic             idle_high,
    input  logic             run_nxt,
    input  logic             run_cur,
    output logic             period_end,
    output logic             byp_q,
    output logic             lvl_q,
    output logic             rise_q,
    output logic             fall_q
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] last_div;
        logic             byp;
        logic             lvl;
        logic             rise;
        logic             fall;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [DIV_W-1:0] high_eff;
    logic             byp_nxt;
    logic             active_phase;

    always_comb begin
        st_d     = st_q;
        byp_nxt  = bypass || (div_val == '0);
        // Clamp keeps at least one count in each phase
        high_eff = (high_val >= div_val) ? div_val - 1'b1 : high_val;

        st_d.last_div = div_val;
        st_d.byp      = byp_nxt;

        if (!run_nxt || !run_cur || byp_nxt || (div_val != st_q.last_div))
            st_d.cnt = '0;
        else if (st_q.cnt >= div_val)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + 1'b1;

        active_phase = (st_d.cnt <= high_eff);
        st_d.lvl     = (run_nxt && !byp_nxt) ? (active_phase ^ idle_high) : idle_high;

        if (byp_nxt) begin
            st_d.rise = run_nxt;
            st_d.fall = run_nxt;
        end else begin
            st_d.rise = st_d.lvl & ~st_q.lvl;
            st_d.fall = ~st_d.lvl & st_q.lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign period_end = st_q.byp || (st_q.cnt >= div_val);
    assign byp_q      = st_q.byp;
    assign lvl_q      = st_q.lvl;
    assign rise_q     = st_q.rise;
    assign fall_q     = st_q.fall;
endmodule

// File: rtl/spi_clk_gen.sv
module spi_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic [DIV_W-1:0] high_val,
    input  logic             bypass,
    input  logic             idle_high,
    input  logic [1:0]       gate_mode,
    input  logic             cs_active,
    output logic             sck,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic run_nxt, run_cur, period_end, byp_q, lvl_q;
    logic byp_line;

    spi_clk_gate i_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_mode  (gate_mode),
        .cs_active  (cs_active),
        .period_end (period_end),
        .run_nxt    (run_nxt),
        .run_cur    (run_cur)
    );

    spi_clk_div #(.DIV_W(DIV_W)) i_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_val    (div_val),
        .high_val   (high_val),
        .bypass     (bypass),
        .idle_high  (idle_high),
        .run_nxt    (run_nxt),
        .run_cur    (run_cur),
        .period_end (period_end),
        .byp_q      (byp_q),
        .lvl_q      (lvl_q),
        .rise_q     (rise_stb),
        .fall_q     (fall_stb)
    );

    // Divide-by-one: enable changes only while the line sits at its idle level
    assign byp_line = idle_high ? (~run_cur | clk) : (run_cur & ~clk);
    assign sck      = byp_q ? byp_line : lvl_q;
endmodule

// File: rtl/spi_clk_chk.sv
module spi_clk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] gate_mode,
    input logic       cs_active,
    input logic       idle_high,
    input logic       sck,
    input logic       rise_stb,
    input logic       fall_stb,
    input logic       run_nxt,
    input logic       run_cur,
    input logic       period_end,
    input logic       byp_q
);
    // R10: strobes never coincide in divided mode
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !byp_q |-> !(rise_stb && fall_stb));

    // R6: once stopped the line sits at the idle level
    p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_nxt ##1 $stable(idle_high)) |-> (sck == idle_high));

    // R8: free-running mode keeps the clock on
    p_free_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_mode == 2'd3) |=> run_cur);

    // R7: tail modes stop only at the end of a period
    p_tail_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cur && !run_nxt && !cs_active && gate_mode != 2'd0 && $stable(gate_mode))
        |-> period_end);

    // R4: divide-by-one marks both edges every running cycle
    p_bypass_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_q && run_cur) |-> (rise_stb && fall_stb));
endmodule

bind spi_clk_gen spi_clk_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_mode  (gate_mode),
    .cs_active  (cs_active),
    .idle_high  (idle_high),
    .sck        (sck),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .run_nxt    (run_nxt),
    .run_cur    (run_cur),
    .period_end (period_end),
    .byp_q      (byp_q)
);

// File: tb/test_spi_clk_gen.sv
module test_spi_clk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_val = 8'd3;
    logic [7:0] high_val = 8'd1;
    logic       bypass = 1'b0;
    logic       idle_high = 1'b0;
    logic [1:0] gate_mode = 2'd3;
    logic       cs_active = 1'b0;
    logic       sck, rise_stb, fall_stb;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    spi_clk_gen i_spi_clk_gen (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .high_val(high_val),
        .bypass(bypass), .idle_high(idle_high), .gate_mode(gate_mode),
        .cs_active(cs_active), .sck(sck), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic align(input string req, input bit ih);
        bit found = 1'b0;
        for (int i = 0; i < 64 && !found; i++) begin
            tick();
            found = ih ? fall_stb : rise_stb;
        end
        check(req, "period start found", int'(found), 1);
    endtask

    // Samples {sck,rise,fall} for whole periods from an aligned start
    task automatic pattern(input string req, input int n, input int h, input bit ih, input int periods);
        for (int k = 0; k < periods * (n + 1); k++) begin
            int  pos   = k % (n + 1);
            bit  ln    = (pos <= h) ^ ih;
            bit  start = (pos == 0);
            bit  mid   = (pos == h + 1);
            bit  er    = ih ? mid : start;
            bit  ef    = ih ? start : mid;
            check(req, $sformatf("line/rise/fall at k=%0d", k),
                  int'({sck, rise_stb, fall_stb}), int'({ln, er, ef}));
            tick();
        end
    endtask

    task automatic t_reset();
        repeat (3) tick();
        check("R11", "outputs in reset", int'({sck, rise_stb, fall_stb}), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_free_run();
        gate_mode = 2'd3; cs_active = 1'b0; idle_high = 1'b0;
        div_val = 8'd3; high_val = 8'd1;
        align("R8", 1'b0);
        pattern("R1 R2 R8 R10", 3, 1, 1'b0, 3);
        div_val = 8'd4; high_val = 8'd1;
        align("R1", 1'b0);
        pattern("R1 R2 R10", 4, 1, 1'b0, 2);
    endtask

    task automatic t_clamp();
        div_val = 8'd3; high_val = 8'd7;
        align("R3", 1'b0);
        pattern("R3", 3, 2, 1'b0, 2);
        div_val = 8'd5; high_val = 8'd5;
        align("R3", 1'b0);
        pattern("R3", 5, 4, 1'b0, 2);
    endtask

    task automatic t_idle_high();
        div_val = 8'd3; high_val = 8'd1; idle_high = 1'b1;
        align("R5", 1'b1);
        pattern("R5 R10", 3, 1, 1'b1, 2);
        gate_mode = 2'd0; cs_active = 1'b0;
        repeat (3) tick();
        for (int i = 0; i < 8; i++) begin
            check("R5 R6", "idle-high line stopped", int'({sck, rise_stb, fall_stb}), 3'b100);
            tick();
        end
        idle_high = 1'b0;
        repeat (3) tick();
    endtask

    task automatic t_tail(input int mode, input int exp_rises);
        int rises = 0;
        div_val = 8'd3; high_val = 8'd1; idle_high = 1'b0;
        gate_mode = 2'(mode); cs_active = 1'b0;
        repeat (20) tick();
        cs_active = 1'b1;
        tick();
        check("R7", "rise at chip-select start", int'(rise_stb), 1);
        tick();
        cs_active = 1'b0;
        tick();
        if (mode == 0) check("R6", "line idle right after drop", int'(sck), 0);
        if (rise_stb) rises++;
        for (int i = 0; i < 19; i++) begin
            tick();
            if (rise_stb) rises++;
        end
        check(mode == 0 ? "R6" : "R7", $sformatf("rises after drop, mode %0d", mode), rises, exp_rises);
        check(mode == 0 ? "R6" : "R7", "line idle at end", int'(sck), 0);
    endtask

    task automatic t_div_change();
        gate_mode = 2'd3; div_val = 8'd3; high_val = 8'd1; idle_high = 1'b0;
        align("R9", 1'b0);
        tick();
        div_val = 8'd7; high_val = 8'd3;
        for (int k = 0; k < 8; k++) begin
            tick();
            check("R9", $sformatf("line after divide change k=%0d", k), int'(sck), k < 4 ? 1 : 0);
        end
        tick();
        check("R9", "rise after first new period", int'(rise_stb), 1);
    endtask

    task automatic t_bypass();
        gate_mode = 2'd3; bypass = 1'b1; idle_high = 1'b0;
        repeat (2) tick();
        check("R4", "bypass clock-high half, idle low", int'({sck, rise_stb, fall_stb}), 3'b011);
        #2;
        check("R4", "bypass clock-low half, idle low", int'(sck), 1);
        idle_high = 1'b1;
        repeat (2) tick();
        check("R4", "bypass clock-high half, idle high", int'(sck), 1);
        #2;
        check("R4", "bypass clock-low half, idle high", int'(sck), 0);
        idle_high = 1'b0; bypass = 1'b0; div_val = 8'd0;
        repeat (2) tick();
        check("R4", "zero divide acts as bypass", int'({sck, rise_stb, fall_stb}), 3'b011);
        #2;
        check("R4", "zero divide clock-low half", int'(sck), 1);
        bypass = 1'b1; div_val = 8'd3; gate_mode = 2'd0; cs_active = 1'b0;
        repeat (3) tick();
        #2;
        check("R4 R6", "bypass gated off", int'({sck, rise_stb, fall_stb}), 0);
        bypass = 1'b0;
    endtask

    initial begin
        t_reset();
        t_free_run();
        t_clamp();
        t_idle_high();
        t_tail(0, 0);
        t_tail(1, 1);
        t_tail(2, 2);
        t_div_change();
        t_bypass();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule